// File: doc/BRIEF.md
# Mixed-Device Memory Map Decoder

This block is a byte-wide memory subsystem on a 16-bit address bus. It holds four storage devices of unequal size: two fixed-content banks, one read/write bank and one small non-volatile bank. The top three address bits divide the space into eight 8-Kbyte blocks. Each device owns one block, and the upper half of the space is left unmapped.

Each address produces one-hot device selects. These are combinational from the address alone. A read strobe returns the addressed byte one clock later, together with a response-valid flag. A write strobe updates the addressed byte on the clock edge, but only for the two writable devices. The non-volatile bank decodes just 11 address bits, so its 2 Kbytes appear four times across its 8-Kbyte block.

The bus accepts one request per cycle and applies no back-pressure. In stream terms, a read is a request that is always ready, and the response comes out on the following cycle with `bus_rvalid` high for exactly one cycle. The caller must take the response in that cycle, because it cannot be stalled.

Top module: `mmap_subsys`

## Requirements
- R1: `dev_sel` is a combinational function of `bus_addr[15:13]` only. Bit 0 is set for 0x0000-0x1FFF, bit 1 for 0x2000-0x3FFF, bit 2 for 0x4000-0x5FFF and bit 3 for 0x6000-0x7FFF. The strobes do not affect it.
- R2: At most one bit of `dev_sel` is ever high, and none is high for addresses 0x8000-0xFFFF.
- R3: When `bus_rd` is high at a rising edge, `bus_rvalid` is high after that edge and `bus_rdata` holds the addressed byte. When `bus_rd` is low, `bus_rvalid` is low after the edge and `bus_rdata` keeps its value.
- R4: The fixed banks return computed bytes, with a = `bus_addr[12:0]`. Bank 0 returns a[7:0] XOR a[12:5]. Bank 1 returns (a[7:0] + a[12:5]) mod 256, XOR 0xAA.
- R5: A write aimed at either fixed bank leaves every byte it returns unchanged.
- R6: The read/write bank stores 8192 distinct bytes, indexed by `bus_addr[12:0]`.
- R7: The non-volatile bank stores 2048 bytes, indexed by `bus_addr[10:0]`. Bits 11 and 12 are ignored, so a byte written at any one of its four aliases reads back at all four.
- R8: A read in 0x8000-0xFFFF returns 0xFF. A write there changes no stored byte in any device.
- R9: When read and write strobes hit the same address in the same cycle, the read returns the content from before that write.
- R10: While reset is asserted and before the first read, `bus_rdata` is 0x00 and `bus_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Byte to write |
| bus_rd | input | 1 | Read strobe, one request per cycle |
| bus_wr | input | 1 | Write strobe, one request per cycle |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when `bus_rdata` holds a response |
| dev_sel | output | 4 | One-hot device select (fixed 0, fixed 1, read/write, non-volatile) |

## Verification
The checker examines properties of the select and response path on every cycle. It confirms that no two selects are active together and that the upper half selects nothing. It also confirms that each read strobe yields exactly one response flag, that `bus_rdata` holds still when no read was made, and that a read with no select returns all ones. Other behaviours depend on stored content and can only be shown by the bench's scenarios. These are the computed fixed-bank bytes, the read-after-write results, the four-way aliasing of the non-volatile bank, the writes that must be ignored, and old-data return on a same-cycle read and write. The bench checks them against a shadow model it updates itself.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  // Device slots; the select vector and the data bus follow this order.
  localparam int DEV_ROM0 = 0;
  localparam int DEV_ROM1 = 1;
  localparam int DEV_RAM  = 2;
  localparam int DEV_NV   = 3;
  localparam int NUM_DEV  = 4;

  // Content variants for the computed fixed banks.
  typedef enum logic [0:0] {
    PAT_XOR_FOLD = 1'b0,
    PAT_SUM_MASK = 1'b1
  } rom_pat_e;
endpackage

// File: rtl/mmap_decoder.sv
module mmap_decoder #(
  parameter int ADDR_W  = 16,
  parameter int SEL_W   = 3,
  parameter int NUM_DEV = 4,
  parameter logic [NUM_DEV*SEL_W-1:0] BLK_MAP = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_DEV-1:0] cs
);
  logic [SEL_W-1:0] blk;
  assign blk = addr[ADDR_W-1 -: SEL_W];

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cmp
    assign cs[i] = (blk == BLK_MAP[i*SEL_W +: SEL_W]);
  end
endmodule

// File: rtl/rom_pattern_bank.sv
module rom_pattern_bank
  import mmap_pkg::*;
#(
  parameter int       AW      = 13,
  parameter int       DATA_W  = 8,
  parameter rom_pat_e PATTERN = PAT_XOR_FOLD
) (
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] lo_part;
  logic [DATA_W-1:0] hi_part;
  assign lo_part = addr[DATA_W-1:0];
  assign hi_part = addr[AW-1 -: DATA_W];

  if (PATTERN == PAT_XOR_FOLD) begin : g_xor
    assign rdata = lo_part ^ hi_part;
  end else begin : g_sum
    localparam logic [DATA_W-1:0] MASK = {(DATA_W/2){2'b10}};
    assign rdata = (lo_part + hi_part) ^ MASK;
  end
endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
  parameter int AW     = 13,
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANE_BITS = $clog2(LANES);
  localparam int WORD_AW   = AW - LANE_BITS;
  localparam int WORDS     = 1 << WORD_AW;

  if (LANES == 1) begin : g_flat
    logic [DATA_W-1:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
    end
    assign rdata = mem[addr];
  end else begin : g_packed
    logic [WORD_AW-1:0]   word;
    logic [LANE_BITS-1:0] lane;
    logic [LANES-1:0][DATA_W-1:0] mem [WORDS];
    assign word = addr[AW-1:LANE_BITS];
    assign lane = addr[LANE_BITS-1:0];
    always_ff @(posedge clk) begin
      if (we) mem[word][lane] <= wdata;
    end
    assign rdata = mem[word][lane];
  end
endmodule

// File: rtl/rd_steer.sv
module rd_steer #(
  parameter int NUM_DEV = 4,
  parameter int DATA_W  = 8
) (
  input  logic [NUM_DEV-1:0]        cs,
  input  logic [NUM_DEV*DATA_W-1:0] dev_data,
  output logic [DATA_W-1:0]         data
);
  logic [DATA_W-1:0] masked [NUM_DEV];
  logic [DATA_W-1:0] acc;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_mask
    assign masked[i] = dev_data[i*DATA_W +: DATA_W] & {DATA_W{cs[i]}};
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_DEV; i++) acc |= masked[i];
    data = (|cs) ? acc : {DATA_W{1'b1}};
  end
endmodule

// File: rtl/mmap_subsys.sv
module mmap_subsys
  import mmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SEL_W     = 3,
  parameter int DATA_W    = 8,
  parameter int NV_AW     = 11,
  parameter int RAM_LANES = 4,
  parameter int ROM0_BLK  = 0,
  parameter int ROM1_BLK  = 1,
  parameter int RAM_BLK   = 2,
  parameter int NV_BLK    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  input  logic               bus_wr,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic [NUM_DEV-1:0] dev_sel
);
  localparam int BLK_AW = ADDR_W - SEL_W;
  localparam logic [NUM_DEV*SEL_W-1:0] BLK_MAP =
    {SEL_W'(NV_BLK), SEL_W'(RAM_BLK), SEL_W'(ROM1_BLK), SEL_W'(ROM0_BLK)};

  logic [BLK_AW-1:0]         blk_off;
  logic [NUM_DEV*DATA_W-1:0] dev_data;
  logic [DATA_W-1:0]         steered;

  assign blk_off = bus_addr[BLK_AW-1:0];

  mmap_decoder #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NUM_DEV(NUM_DEV), .BLK_MAP(BLK_MAP)
  ) u_dec (
    .addr(bus_addr),
    .cs  (dev_sel)
  );

  rom_pattern_bank #(.AW(BLK_AW), .DATA_W(DATA_W), .PATTERN(PAT_XOR_FOLD)) u_rom0 (
    .addr (blk_off),
    .rdata(dev_data[DEV_ROM0*DATA_W +: DATA_W])
  );

  rom_pattern_bank #(.AW(BLK_AW), .DATA_W(DATA_W), .PATTERN(PAT_SUM_MASK)) u_rom1 (
    .addr (blk_off),
    .rdata(dev_data[DEV_ROM1*DATA_W +: DATA_W])
  );

  sram_bank #(.AW(BLK_AW), .DATA_W(DATA_W), .LANES(RAM_LANES)) u_ram (
    .clk  (clk),
    .we   (bus_wr & dev_sel[DEV_RAM]),
    .addr (blk_off),
    .wdata(bus_wdata),
    .rdata(dev_data[DEV_RAM*DATA_W +: DATA_W])
  );

  sram_bank #(.AW(NV_AW), .DATA_W(DATA_W), .LANES(1)) u_nv (
    .clk  (clk),
    .we   (bus_wr & dev_sel[DEV_NV]),
    .addr (bus_addr[NV_AW-1:0]),
    .wdata(bus_wdata),
    .rdata(dev_data[DEV_NV*DATA_W +: DATA_W])
  );

  rd_steer #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) u_steer (
    .cs      (dev_sel),
    .dev_data(dev_data),
    .data    (steered)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= steered;
    end
  end
endmodule

// File: rtl/mmap_subsys_chk.sv
module mmap_subsys_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_DEV-1:0] dev_sel
);
  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel)); // R2

  AST_UPPER_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[ADDR_W-1] |-> (dev_sel == '0)); // R2

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (!bus_rvalid && $stable(bus_rdata))); // R3

  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && dev_sel == '0) |=> (bus_rdata == {DATA_W{1'b1}})); // R8
endmodule

bind mmap_subsys mmap_subsys_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DEV(mmap_pkg::NUM_DEV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .dev_sel   (dev_sel)
);

// File: tb/mmap_subsys_tb.sv
`timescale 1ns/1ps
module mmap_subsys_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  dev_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  logic [7:0] ram_m [int];
  logic [7:0] nv_m  [int];

  mmap_subsys u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .dev_sel(dev_sel)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(input int bank, input logic [12:0] a);
    logic [7:0] s;
    if (bank == 0) return a[7:0] ^ a[12:5];
    s = a[7:0] + a[12:5];
    return s ^ 8'hAA;
  endfunction

  function automatic logic [3:0] exp_sel(input logic [15:0] a);
    return a[15] ? 4'b0000 : (4'b0001 << a[14:13]);
  endfunction

  // Returns 1 when the expected byte is known from the model.
  function automatic bit exp_read(input logic [15:0] a, output logic [7:0] d);
    d = 8'hFF;
    case (a[15:13])
      3'd0: d = rom_byte(0, a[12:0]);
      3'd1: d = rom_byte(1, a[12:0]);
      3'd2: begin
        if (!ram_m.exists(int'(a[12:0]))) return 1'b0;
        d = ram_m[int'(a[12:0])];
      end
      3'd3: begin
        if (!nv_m.exists(int'(a[10:0]))) return 1'b0;
        d = nv_m[int'(a[10:0])];
      end
      default: d = 8'hFF;
    endcase
    return 1'b1;
  endfunction

  function automatic string region_tag(input logic [15:0] a);
    case (a[15:13])
      3'd0, 3'd1: return "R4";
      3'd2:       return "R6";
      3'd3:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Called at a negedge; drives one request, checks the result at the next negedge.
  task automatic op(input logic [15:0] a, input logic [7:0] wd, input bit rd,
                    input bit wr, input string tag);
    logic [7:0] ed;
    logic [7:0] prev;
    bit known;
    bus_addr = a; bus_wdata = wd; bus_rd = rd; bus_wr = wr;
    #1;
    check("R1 R2 select", dev_sel, exp_sel(a));
    known = exp_read(a, ed);
    prev = bus_rdata;
    @(negedge clk);
    check("R3 valid", bus_rvalid, rd);
    if (rd && known)
      check((tag == "") ? region_tag(a) : tag, bus_rdata, ed);
    else if (!rd)
      check("R3 hold", bus_rdata, prev);
    if (wr) begin
      if (a[15:13] == 3'd2) ram_m[int'(a[12:0])] = wd;
      else if (a[15:13] == 3'd3) nv_m[int'(a[10:0])] = wd;
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 rdata in reset", bus_rdata, 8'h00);
    check("R10 rvalid in reset", bus_rvalid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rdata after reset", bus_rdata, 8'h00);
    check("R10 rvalid after reset", bus_rvalid, 1'b0);

    // R1: select boundaries, strobes idle
    op(16'h0000, 8'h00, 0, 0, "");
    op(16'h1FFF, 8'h00, 0, 0, "");
    op(16'h2000, 8'h00, 0, 0, "");
    op(16'h5FFF, 8'h00, 0, 0, "");
    op(16'h6000, 8'h00, 0, 0, "");
    op(16'h7FFF, 8'h00, 0, 0, "");
    op(16'h8000, 8'h00, 0, 0, "");
    op(16'hFFFF, 8'h00, 0, 0, "");

    // R4: fixed bank reads at edges
    op(16'h0000, 8'h00, 1, 0, "R4");
    op(16'h1FFF, 8'h00, 1, 0, "R4");
    op(16'h2000, 8'h00, 1, 0, "R4");
    op(16'h3ABC, 8'h00, 1, 0, "R4");

    // R5: writes into fixed banks are ignored
    op(16'h0010, 8'h5A, 0, 1, "");
    op(16'h0010, 8'h00, 1, 0, "R5");
    op(16'h2777, 8'hC3, 0, 1, "");
    op(16'h2777, 8'h00, 1, 0, "R5");

    // R6: distinct RAM bytes, no aliasing between 0x4000/0x4800/0x5000/0x5FFF
    op(16'h4000, 8'h11, 0, 1, "");
    op(16'h4800, 8'h22, 0, 1, "");
    op(16'h5000, 8'h33, 0, 1, "");
    op(16'h5FFF, 8'h44, 0, 1, "");
    op(16'h4000, 8'h00, 1, 0, "R6");
    op(16'h4800, 8'h00, 1, 0, "R6");
    op(16'h5000, 8'h00, 1, 0, "R6");
    op(16'h5FFF, 8'h00, 1, 0, "R6");

    // R7: one write, four aliases
    op(16'h6123, 8'h9E, 0, 1, "");
    op(16'h6123, 8'h00, 1, 0, "R7");
    op(16'h6923, 8'h00, 1, 0, "R7");
    op(16'h7123, 8'h00, 1, 0, "R7");
    op(16'h7923, 8'h00, 1, 0, "R7");
    op(16'h7FFF, 8'h6D, 0, 1, "");
    op(16'h67FF, 8'h00, 1, 0, "R7");
    op(16'h6FFF, 8'h00, 1, 0, "R7");

    // R8: unmapped write touches nothing, read gives 0xFF
    op(16'h8123, 8'h00, 0, 1, "");
    op(16'hC000, 8'h77, 0, 1, "");
    op(16'h8123, 8'h00, 1, 0, "R8");
    op(16'h6123, 8'h00, 1, 0, "R8");
    op(16'h4000, 8'h00, 1, 0, "R8");

    // R9: simultaneous read and write return old data
    op(16'h4000, 8'hE1, 1, 1, "R9");
    op(16'h4000, 8'h00, 1, 0, "R9");
    op(16'h7123, 8'h0F, 1, 1, "R9");
    op(16'h6123, 8'h00, 1, 0, "R9");

    // Random traffic mixed across regions
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      int r;
      r = int'($urandom % 10);
      a = 16'($urandom);
      if (r < 2)      a[15] = 1'b0 ;
      if (r < 2)      a[14] = 1'b0;
      else if (r < 5) a = {3'b010, 3'($urandom % 8), 3'b000, 4'($urandom % 16)};
      else if (r < 8) a = {3'b011, 2'($urandom), 3'b000, 8'($urandom % 32)};
      else            a[15] = 1'b1;
      op(a, 8'($urandom), bit'($urandom % 2), bit'($urandom % 2), "");
    end

    report();
  end
endmodule